// File: doc/BRIEF.md
# Dual-Source Boot Loader

This block is a hardware boot sequencer that runs once after reset. It starts with one read of a configuration word at a fixed external memory address. One bit of that word chooses where the boot image comes from. The image can arrive as a byte stream from a serial receiver, or as byte reads from the low byte of the parallel external memory port. The sequencer builds 16-bit words from the chosen bytes. The first word is a word count and the second is a load address. After those two words come the program words, which are written into ascending program RAM locations.

When the last word has been written, the block raises `done`. It also presents the load address on `jump_addr`, so the core can branch there. The block checks every destination before it writes. If a destination lands outside the loadable regions, or the next address would pass the top of the address space, the block raises a sticky error and stops.

Both byte sources use valid/ready handshakes.

- **Serial side:** a byte is taken on any clock where `spi_valid` and `spi_ready` are both high. `spi_ready` depends only on internal state, so the sender may hold `spi_valid` high for as long as it likes.
- **Memory side:** the read is presented on `mem_rd_valid` and `mem_rd_addr`. It completes on the clock where `mem_rd_ready` is high. `mem_rd_data` must be valid in that same cycle. The request address stays fixed until the read completes.
- **RAM side:** the write port has no back-pressure. The RAM must accept a write on every cycle where `ram_we` is high.

At most one byte is taken per clock.

Top module: `boot_loader`

## Requirements
- R1: After reset the block issues one memory read at address 0xC000 (`mem_rd_valid` high, `mem_rd_addr` = 0xC000) before it takes any byte. Bit 15 of the returned word picks the source: 0 selects the serial stream and 1 selects the parallel port. All other bits of that word are ignored.
- R2: With the serial source selected, bytes are taken only on clocks where `spi_valid` and `spi_ready` are both high, and the memory port stays idle. `spi_ready` and `mem_rd_valid` are never high in the same cycle.
- R3: With the parallel source selected, byte reads go to 0xC001, 0xC002 and so on, one address per completed read. Only bits 7:0 of `mem_rd_data` are used; bits 15:8 are ignored.
- R4: Each word is built from two consecutive bytes, the first byte being bits 7:0. The first word is the count and the second word is the load address.
- R5: Program word k (counting from 0) is written to address start+k. Each word produces exactly one `ram_we` pulse, in the cycle after the clock that took its second byte. Every written address is loadable.
- R6: A count of zero raises `done` with no writes, whatever the load address is, and `jump_addr` shows that address.
- R7: Loadable addresses are 0x0000–0x007F and 0x8000–0xFFFF. A load address that is not loadable raises `err` with no writes. If the address after a written word is outside the loadable ranges, or would pass 0xFFFF, while words remain, the block raises `err` after writing the valid words.
- R8: After the last word, `done` stays high and `jump_addr` equals the load address. No further bytes are taken (`spi_ready` and `mem_rd_valid` low) and no further writes occur.
- R9: `err` is sticky until reset; after it rises, no bytes are taken and no writes occur. `done` and `err` are never high together. In reset, `done`, `err` and `ram_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_ready | input | 1 | Read completes this cycle; data valid |
| mem_rd_data | input | 16 | Memory read data |
| spi_valid | input | 1 | Serial byte available |
| spi_data | input | 8 | Serial byte |
| spi_ready | output | 1 | Block takes the serial byte this cycle |
| ram_we | output | 1 | Program RAM write strobe |
| ram_addr | output | 16 | Program RAM write address |
| ram_wdata | output | 16 | Program RAM write data |
| done | output | 1 | Load finished |
| err | output | 1 | Sticky range error |
| jump_addr | output | 16 | Load address to branch to |

## Verification
The assertions rely on three properties of the environment:

- a memory read completes only through `mem_rd_ready`, with data valid in that cycle;
- the serial sender keeps `spi_data` stable while it offers a byte;
- the RAM never stalls a write.

The stimulus drives every input on the falling edge, so it meets these assumptions. The ready and valid patterns come from a pseudo-random sequence with gaps. The parallel memory model answers from whatever address is presented. The serial stream carries trailing bytes beyond the image, which shows whether the block stops taking bytes at the right point.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [1:0] {ST_CFG, ST_LOAD, ST_DONE, ST_ERR} boot_state_t;
  typedef enum logic [1:0] {W_COUNT, W_START, W_DATA} word_kind_t;
endpackage

// File: rtl/boot_byte_mux.sv
module boot_byte_mux #(
  parameter int WORD_W = 16,
  parameter logic [WORD_W-1:0] PTR_INIT = 16'hC001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              src_par,
  input  logic              mem_rd_ready,
  input  logic [WORD_W/2-1:0] mem_byte,
  input  logic              spi_valid,
  input  logic [WORD_W/2-1:0] spi_data,
  output logic              spi_ready,
  output logic              par_req,
  output logic [WORD_W-1:0] par_addr,
  output logic              byte_fire,
  output logic [WORD_W/2-1:0] byte_data
);
  assign spi_ready = en && !src_par;
  assign par_req   = en && src_par;
  assign byte_fire = src_par ? (par_req && mem_rd_ready) : (spi_valid && spi_ready);
  assign byte_data = src_par ? mem_byte : spi_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_addr <= PTR_INIT;
    else if (par_req && mem_rd_ready) par_addr <= par_addr + WORD_W'(1);
  end

  // R2: never two sources at once
  a_r2_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(spi_ready && par_req));
endmodule

// File: rtl/boot_word_asm.sv
module boot_word_asm #(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                byte_fire,
  input  logic [WORD_W/2-1:0] byte_data,
  output logic                word_fire,
  output logic [WORD_W-1:0]   word
);
  logic                have_lo;
  logic [WORD_W/2-1:0] lo_q;

  assign word_fire = byte_fire && have_lo;
  assign word      = {byte_data, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_lo <= 1'b0;
      lo_q    <= '0;
    end else if (byte_fire) begin
      have_lo <= !have_lo;
      if (!have_lo) lo_q <= byte_data;
    end
  end
endmodule

// File: rtl/boot_loader.sv
module boot_loader #(
  parameter int WORD_W = 16,
  parameter logic [WORD_W-1:0] CFG_ADDR = 16'hC000,
  parameter int SRC_BIT = 15,
  parameter int INT_WORDS = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                mem_rd_valid,
  output logic [WORD_W-1:0]   mem_rd_addr,
  input  logic                mem_rd_ready,
  input  logic [WORD_W-1:0]   mem_rd_data,
  input  logic                spi_valid,
  input  logic [WORD_W/2-1:0] spi_data,
  output logic                spi_ready,
  output logic                ram_we,
  output logic [WORD_W-1:0]   ram_addr,
  output logic [WORD_W-1:0]   ram_wdata,
  output logic                done,
  output logic                err,
  output logic [WORD_W-1:0]   jump_addr
);
  import boot_pkg::*;
  localparam int BYTE_W = WORD_W / 2;
  localparam logic [WORD_W-1:0] TOP_ADDR = '1;

  function automatic logic addr_ok(input logic [WORD_W-1:0] a);
    return (a < WORD_W'(INT_WORDS)) || a[WORD_W-1];
  endfunction

  boot_state_t       state;
  word_kind_t        kind;
  logic              src_par;
  logic [WORD_W-1:0] remaining, cur_addr, start_r, next_addr;
  logic              par_req, byte_fire, word_fire;
  logic [WORD_W-1:0] par_addr, word;
  logic [BYTE_W-1:0] byte_data;
  logic              unused_mem_bits;

  assign unused_mem_bits = ^mem_rd_data;
  assign next_addr = cur_addr + WORD_W'(1);

  boot_byte_mux #(.WORD_W(WORD_W), .PTR_INIT(CFG_ADDR + WORD_W'(1))) u_src (
    .clk(clk), .rst_n(rst_n), .en(state == ST_LOAD), .src_par(src_par),
    .mem_rd_ready(mem_rd_ready), .mem_byte(mem_rd_data[BYTE_W-1:0]),
    .spi_valid(spi_valid), .spi_data(spi_data), .spi_ready(spi_ready),
    .par_req(par_req), .par_addr(par_addr),
    .byte_fire(byte_fire), .byte_data(byte_data)
  );

  boot_word_asm #(.WORD_W(WORD_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .byte_fire(byte_fire), .byte_data(byte_data),
    .word_fire(word_fire), .word(word)
  );

  assign mem_rd_valid = (state == ST_CFG) || par_req;
  assign mem_rd_addr  = (state == ST_CFG) ? CFG_ADDR : par_addr;
  assign done         = (state == ST_DONE);
  assign err          = (state == ST_ERR);
  assign jump_addr    = start_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_CFG;
      kind      <= W_COUNT;
      src_par   <= 1'b0;
      remaining <= '0;
      cur_addr  <= '0;
      start_r   <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= 1'b0;
      unique case (state)
        ST_CFG: if (mem_rd_ready) begin
          src_par <= mem_rd_data[SRC_BIT];
          state   <= ST_LOAD;
        end
        ST_LOAD: if (word_fire) begin
          unique case (kind)
            W_COUNT: begin
              remaining <= word;
              kind      <= W_START;
            end
            W_START: begin
              start_r  <= word;
              cur_addr <= word;
              kind     <= W_DATA;
              if (remaining == '0) state <= ST_DONE;
              else if (!addr_ok(word)) state <= ST_ERR;
            end
            default: begin
              ram_we    <= 1'b1;
              ram_addr  <= cur_addr;
              ram_wdata <= word;
              remaining <= remaining - WORD_W'(1);
              cur_addr  <= next_addr;
              if (remaining == WORD_W'(1)) state <= ST_DONE;
              else if (cur_addr == TOP_ADDR || !addr_ok(next_addr)) state <= ST_ERR;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  // R5: every write lands in a loadable region
  a_r5_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> addr_ok(ram_addr));
  // R9: error is sticky and silences the write port
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err && !ram_we);
  // R9: completion and error exclude each other
  a_r9_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  // R8: completion holds with a stable jump target
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(jump_addr) && !spi_ready && !mem_rd_valid);
  // R8: no write after the cycle completion was reached
  a_r8_no_late_write: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(done) |-> !ram_we);
  // R2: serial ready and memory request never overlap
  a_r2_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(spi_ready && mem_rd_valid));
endmodule

// File: tb/boot_loader_tb.sv
module boot_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_rd_valid, mem_rd_ready = 1'b0;
  logic [15:0] mem_rd_addr, mem_rd_data = '0;
  logic        spi_valid = 1'b0, spi_ready;
  logic [7:0]  spi_data = '0;
  logic        ram_we, done, err;
  logic [15:0] ram_addr, ram_wdata, jump_addr;

  always #4 clk = ~clk;

  boot_loader u_dut (
    .clk(clk), .rst_n(rst_n), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data), .spi_valid(spi_valid),
    .spi_data(spi_data), .spi_ready(spi_ready), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .done(done), .err(err), .jump_addr(jump_addr)
  );

  int total = 0, bad = 0;
  logic [15:0] lf = 16'hACE1;
  logic [15:0] mem [int];
  logic [7:0]  spi_q [$];
  logic [15:0] img_q [$];
  logic [15:0] exp_a [$], exp_d [$];
  logic        exp_err, spi_pend;

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic loadable(input int a);
    return (a < 128) || (a >= 32768 && a <= 65535);
  endfunction

  task automatic step();
    @(negedge clk);
    if (spi_pend) void'(spi_q.pop_front());
    if (ram_we) begin
      if (exp_a.size() == 0) check(1'b0, "R5", "unexpected write addr", ram_addr, 0);
      else begin
        check(ram_addr == exp_a[0], "R5", "write addr", ram_addr, exp_a[0]);
        check(ram_wdata == exp_d[0], "R4", "write data", ram_wdata, exp_d[0]);
        void'(exp_a.pop_front()); void'(exp_d.pop_front());
      end
    end
    if (err && !exp_err) check(1'b0, "R7", "err raised unexpectedly", err, 0);
    if (done && (exp_err || exp_a.size() != 0))
      check(1'b0, "R8", "done too early", exp_a.size(), 0);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    spi_valid = (spi_q.size() > 0) && (lf[0] || lf[3]);
    spi_data  = (spi_q.size() > 0) ? spi_q[0] : 8'h00;
    mem_rd_ready = lf[1] || lf[5];
    mem_rd_data  = mem.exists(int'(mem_rd_addr)) ? mem[int'(mem_rd_addr)] : 16'hDEAD;
    spi_pend = spi_valid && spi_ready;
  endtask

  task automatic run_case(input logic par, input logic [15:0] cnt, input logic [15:0] start,
                          input int extra, input string name);
    logic [7:0] bytes [$];
    int consumed, a, wd, ok_done, spi_left;
    bytes = {cnt[7:0], cnt[15:8], start[7:0], start[15:8]};
    foreach (img_q[i]) begin bytes.push_back(img_q[i][7:0]); bytes.push_back(img_q[i][15:8]); end
    exp_a.delete(); exp_d.delete(); exp_err = 1'b0; consumed = 4;
    if (cnt != 0) begin
      if (!loadable(int'(start))) exp_err = 1'b1;
      else begin
        a = int'(start);
        for (int k = 0; k < int'(cnt); k++) begin
          exp_a.push_back(16'(a)); exp_d.push_back(img_q[k]); consumed += 2;
          if (k == int'(cnt) - 1) break;
          if (a == 65535 || !loadable(a + 1)) begin exp_err = 1'b1; break; end
          a++;
        end
      end
    end
    mem.delete(); spi_q.delete();
    mem[32'hC000] = par ? 16'h8001 : 16'h7ABC;
    for (int i = 0; i < bytes.size() + 8; i++)
      mem[32'hC001 + i] = {8'hE5, (i < bytes.size()) ? bytes[i] : 8'h77};
    if (!par) begin
      foreach (bytes[i]) spi_q.push_back(bytes[i]);
      for (int i = 0; i < extra; i++) spi_q.push_back(8'h5A);
    end
    // reset
    rst_n = 1'b0; spi_valid = 1'b0; mem_rd_ready = 1'b0; spi_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(!done && !err && !ram_we && !spi_ready, "R9", {name, " reset outputs"},
          {done, err, ram_we, spi_ready}, 0);
    check(mem_rd_valid && mem_rd_addr == 16'hC000, "R1", {name, " config read"},
          {mem_rd_valid, mem_rd_addr}, 32'h1C000);
    wd = 0;
    while (!(done || err) && wd < 3000) begin step(); wd++; end
    check(wd < 3000, "R8", {name, " watchdog"}, wd, 3000);
    repeat (6) step();
    check(err == exp_err && done == !exp_err, exp_err ? "R7" : "R8", {name, " final flags"},
          {done, err}, {!exp_err, exp_err});
    check(exp_a.size() == 0, "R5", {name, " writes outstanding"}, exp_a.size(), 0);
    if (!exp_err) check(jump_addr == start, cnt == 0 ? "R6" : "R8", {name, " jump"}, jump_addr, start);
    check(!mem_rd_valid && !spi_ready, "R9", {name, " no more requests"},
          {mem_rd_valid, spi_ready}, 0);
    if (!par) begin
      spi_left = bytes.size() - consumed + extra;
      check(spi_q.size() == spi_left, "R2", {name, " serial bytes left"}, spi_q.size(), spi_left);
    end
    ok_done = 0;
  endtask

  initial begin
    img_q = {16'h1234, 16'hBEEF, 16'h00FF};
    run_case(1'b0, 16'd3, 16'h0010, 2, "r2_r4 serial internal");
    img_q = {16'hA5C3, 16'h0102, 16'hFFFE, 16'h8000};
    run_case(1'b1, 16'd4, 16'h8000, 0, "r3 parallel external");
    img_q = {16'h1111};
    run_case(1'b0, 16'd0, 16'h1234, 2, "r6 zero count");
    img_q = {16'hC0DE, 16'hCAFE, 16'hF00D};
    run_case(1'b1, 16'd3, 16'h007E, 0, "r7 leave internal");
    img_q = {16'h0001, 16'h0002};
    run_case(1'b0, 16'd2, 16'h4000, 3, "r7 bad start");
    img_q = {16'h0AAA, 16'h0BBB, 16'h0CCC};
    run_case(1'b0, 16'd3, 16'hFFFE, 1, "r7 wrap");
    img_q = {16'h7F7F};
    run_case(1'b0, 16'd1, 16'h007F, 2, "r5 last internal");
    img_q.delete();
    for (int i = 0; i < 20; i++) img_q.push_back(16'((i * 16'h3A7) ^ 16'h5C00));
    run_case(1'b1, 16'd20, 16'hA000, 0, "r5 parallel burst");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule